// File: doc/BRIEF.md
# Port-Limited Operand Read Stage

This block sits between register renaming and the reorder buffer. Each cycle it can take one group of up to three renamed micro-ops. Each micro-op carries up to two source registers, up to two destination registers, and a reorder-buffer tag. For every source, the stage works out where the operand comes from. There are three possible origins: the committed register file, the stored result of a producer that has executed but not yet retired, or a future write-back from a producer that has not yet executed. It then emits one record per group that gives, for each source, its origin, the tag involved and the value when the value is known.

The committed register file has only two read ports. Every source reference that must be served from that file consumes one port slot, even if the same register appears several times in the group. A group with N such references therefore occupies the stage for ceil(N/2) cycles, with a minimum of one. During the extra cycles the upstream ready signal is held low.

Any register that has an in-flight writer bypasses the file entirely. The writer may be an older unretired micro-op or an earlier micro-op in the same group. This means that moving a register onto itself early in a group makes every later read of that register free of port cost. A per-register tracker records the youngest producer tag and whether that producer has executed. The tracker is updated on allocation, on execution write-back and on retirement, and it is cleared by reset or flush.

Top module: `opr_read_stage`

## Requirements
- R1: A group is taken on a clock edge where `in_valid` and `in_ready` are both high. After reset `in_ready` is 1 and `out_valid` is 0.
- R2: A valid source whose register has no in-flight writer gets origin code 01 (committed file). Its data is the committed value, written by retirement, and its tag field is 0.
- R3: A valid source whose youngest in-flight writer has executed gets origin code 10. Its tag field is that writer's tag and its data is the value that writer produced at execution. No file read port is used.
- R4: A valid source whose youngest in-flight writer has not executed gets origin code 11 (pending). Its tag field is the writer's tag and its data is 0.
- R5: If an earlier micro-op in the same group writes a source's register, the source is pending on the tag of the youngest such micro-op. A micro-op's own destinations never count for its own sources.
- R6: A group with N file-sourced references produces its record exactly max(1, ceil(N/2)) cycles after acceptance, with `out_valid` high for one cycle. `in_ready` is 0 in between. Repeated references to the same register each count toward N.
- R7: Retirement writes the committed file. It clears a register's tracking only when the retiring tag equals that register's youngest recorded tag.
- R8: Reset or `flush` clears all tracking and discards any group in progress, so no record is emitted for it. `in_ready` is 0 while `flush` is high.
- R9: Sources of an invalid micro-op, and unused source slots, report origin 00 with tag and data 0.
- R10: A write-back that arrives in the acceptance cycle for a not-yet-executed tracked producer is forwarded. The source reports origin 10 with the write-back data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears tracking and drops the current group |
| in_valid | input | 1 | Upstream group offered |
| in_ready | output | 1 | Stage can take a group |
| in_uop_valid | input | GROUP | Per-micro-op valid |
| in_uop_tag | input | GROUP*TW | Per-micro-op reorder tag |
| in_src_valid | input | GROUP*NSRC | Per-source valid, micro-op major |
| in_src_reg | input | GROUP*NSRC*RW | Source register numbers |
| in_dst_valid | input | GROUP*NDST | Per-destination valid |
| in_dst_reg | input | GROUP*NDST*RW | Destination register numbers |
| exec_valid | input | 1 | Execution write-back strobe |
| exec_tag | input | TW | Tag of the executed producer |
| exec_data | input | DW | Result value |
| ret_valid | input | 1 | Retirement write strobe |
| ret_reg | input | RW | Register being committed |
| ret_tag | input | TW | Tag of the retiring producer |
| ret_data | input | DW | Value committed |
| out_valid | output | 1 | Group record valid (one cycle) |
| out_uop_valid | output | GROUP | Valid bits of the recorded group |
| out_uop_tag | output | GROUP*TW | Tags of the recorded group |
| out_src_kind | output | GROUP*NSRC*2 | Origin per source: 00 none, 01 file, 10 executed producer, 11 pending |
| out_src_tag | output | GROUP*NSRC*TW | Producer tag per source |
| out_src_data | output | GROUP*NSRC*DW | Operand value per source |

## Verification
Random groups with register numbers drawn from a small set produce heavy overlap between readers and writers. This sorts sources into file, executed-producer and pending cases, and the producers are executed and retired in random order. Directed groups isolate specific effects. A group of five file references shows the per-reference port cost. A group opening with a self-move shows how an intra-group writer removes that cost. A retire with a stale tag is distinguished from a matching one. A write-back landing in the acceptance cycle is shown to be forwarded. A flush issued mid-drain confirms that no record escapes and that tracking is wiped.

// File: rtl/opr_pkg.sv
package opr_pkg;

  // Origin code reported for every source slot
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_FILE = 2'b01,
    SRC_ROB  = 2'b10,
    SRC_PEND = 2'b11
  } src_kind_e;

endpackage

// File: rtl/opr_tracker.sv
module opr_tracker #(
  parameter int NREG  = 8,
  parameter int TW    = 4,
  parameter int GROUP = 3,
  parameter int NDST  = 2,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     alloc_en,
  input  logic [GROUP-1:0]         uop_valid,
  input  logic [GROUP*TW-1:0]      uop_tag,
  input  logic [GROUP*NDST-1:0]    dst_valid,
  input  logic [GROUP*NDST*RW-1:0] dst_reg,
  input  logic                     exec_valid,
  input  logic [TW-1:0]            exec_tag,
  input  logic                     ret_valid,
  input  logic [RW-1:0]            ret_reg,
  input  logic [TW-1:0]            ret_tag,
  output logic [NREG-1:0]          trk_busy,
  output logic [NREG*TW-1:0]       trk_tag,
  output logic [NREG-1:0]          trk_done
);

  logic [TW-1:0]   tag_q [NREG];
  logic [NREG-1:0] busy_q;
  logic [NREG-1:0] done_q;
  logic [NREG-1:0] alloc_mask;

  // Registers receiving a new youngest producer this cycle
  always_comb begin
    alloc_mask = '0;
    for (int i = 0; i < GROUP; i++)
      for (int d = 0; d < NDST; d++)
        if (alloc_en && uop_valid[i] && dst_valid[i*NDST+d])
          alloc_mask[dst_reg[(i*NDST+d)*RW +: RW]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy_q <= '0;
      done_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (exec_valid && busy_q[r] && tag_q[r] == exec_tag)
          done_q[r] <= 1'b1;
        if (ret_valid && busy_q[r] && ret_reg == RW'(r) && tag_q[r] == ret_tag)
          busy_q[r] <= 1'b0;
      end
      // Allocation wins; later micro-ops overwrite earlier ones
      for (int i = 0; i < GROUP; i++)
        for (int d = 0; d < NDST; d++)
          if (alloc_en && uop_valid[i] && dst_valid[i*NDST+d]) begin
            busy_q[dst_reg[(i*NDST+d)*RW +: RW]] <= 1'b1;
            done_q[dst_reg[(i*NDST+d)*RW +: RW]] <= 1'b0;
            tag_q[dst_reg[(i*NDST+d)*RW +: RW]]  <= uop_tag[i*TW +: TW];
          end
    end
  end

  assign trk_busy = busy_q;
  assign trk_done = done_q;

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_flat
      assign trk_tag[r*TW +: TW] = tag_q[r];

      // R3: write-back of the tracked producer marks it executed
      a_r3_exec_marks_done: assert property (@(posedge clk) disable iff (rst || flush)
        (exec_valid && busy_q[r] && tag_q[r] == exec_tag && !alloc_mask[r])
        |=> done_q[r]);
    end
  endgenerate

  // R7: matching retirement releases the register
  a_r7_retire_clears: assert property (@(posedge clk) disable iff (rst || flush)
    (ret_valid && busy_q[ret_reg] && tag_q[ret_reg] == ret_tag && !alloc_mask[ret_reg])
    |=> !busy_q[$past(ret_reg)]);

  // R7: a stale tag leaves tracking untouched
  a_r7_stale_keeps: assert property (@(posedge clk) disable iff (rst || flush)
    (ret_valid && busy_q[ret_reg] && tag_q[ret_reg] != ret_tag)
    |=> busy_q[$past(ret_reg)]);

endmodule

// File: rtl/opr_classify.sv
module opr_classify
  import opr_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int TW    = 4,
  parameter int GROUP = 3,
  parameter int NSRC  = 2,
  parameter int NDST  = 2,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int NREF = GROUP * NSRC,
  localparam int NROB = 1 << TW
) (
  input  logic [GROUP-1:0]         uop_valid,
  input  logic [GROUP*TW-1:0]      uop_tag,
  input  logic [NREF-1:0]          src_valid,
  input  logic [NREF*RW-1:0]       src_reg,
  input  logic [GROUP*NDST-1:0]    dst_valid,
  input  logic [GROUP*NDST*RW-1:0] dst_reg,
  input  logic [NREG-1:0]          trk_busy,
  input  logic [NREG*TW-1:0]       trk_tag,
  input  logic [NREG-1:0]          trk_done,
  input  logic [NROB*DW-1:0]       rob_vals,
  input  logic                     exec_valid,
  input  logic [TW-1:0]            exec_tag,
  input  logic [DW-1:0]            exec_data,
  output logic [NREF*2-1:0]        kind,
  output logic [NREF*TW-1:0]       tag,
  output logic [NREF*DW-1:0]       data,
  output logic [NREF-1:0]          need_file
);

  generate
    for (genvar k = 0; k < NREF; k++) begin : g_ref
      localparam int UI = k / NSRC;
      logic [RW-1:0] rreg;
      logic [TW-1:0] ptag, htag, k_tag;
      logic          hit;
      logic [DW-1:0] k_data;
      src_kind_e     k_kind;

      always_comb begin
        rreg   = src_reg[k*RW +: RW];
        ptag   = trk_tag[rreg*TW +: TW];
        hit    = 1'b0;
        htag   = '0;
        k_kind = SRC_NONE;
        k_tag  = '0;
        k_data = '0;
        // Youngest earlier writer inside the group
        for (int j = 0; j < UI; j++)
          for (int d = 0; d < NDST; d++)
            if (uop_valid[j] && dst_valid[j*NDST+d] &&
                dst_reg[(j*NDST+d)*RW +: RW] == rreg) begin
              hit  = 1'b1;
              htag = uop_tag[j*TW +: TW];
            end
        if (uop_valid[UI] && src_valid[k]) begin
          if (hit) begin
            k_kind = SRC_PEND;
            k_tag  = htag;
          end else if (trk_busy[rreg]) begin
            k_tag = ptag;
            if (trk_done[rreg]) begin
              k_kind = SRC_ROB;
              k_data = rob_vals[ptag*DW +: DW];
            end else if (exec_valid && exec_tag == ptag) begin
              k_kind = SRC_ROB;
              k_data = exec_data;
            end else begin
              k_kind = SRC_PEND;
            end
          end else begin
            k_kind = SRC_FILE;
          end
        end
      end

      assign kind[k*2 +: 2]   = k_kind;
      assign tag[k*TW +: TW]  = k_tag;
      assign data[k*DW +: DW] = k_data;
      assign need_file[k]     = (k_kind == SRC_FILE);
    end
  endgenerate

endmodule

// File: rtl/opr_port_pick.sv
module opr_port_pick #(
  parameter int NREF  = 6,
  parameter int PORTS = 2,
  localparam int IW   = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic [NREF-1:0]     need,
  output logic [PORTS-1:0]    pick_en,
  output logic [PORTS*IW-1:0] pick_idx,
  output logic [NREF-1:0]     remain
);

  // Oldest-first: each port takes the lowest still-unserved reference
  always_comb begin
    logic found;
    remain   = need;
    pick_en  = '0;
    pick_idx = '0;
    for (int p = 0; p < PORTS; p++) begin
      found = 1'b0;
      for (int k = 0; k < NREF; k++)
        if (!found && remain[k]) begin
          found               = 1'b1;
          pick_en[p]          = 1'b1;
          pick_idx[p*IW +: IW] = IW'(k);
        end
      if (found) remain[pick_idx[p*IW +: IW]] = 1'b0;
    end
  end

endmodule

// File: rtl/opr_commit_rf.sv
module opr_commit_rf #(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int PORTS = 2,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [RW-1:0]         waddr,
  input  logic [DW-1:0]         wdata,
  input  logic [PORTS*RW-1:0]   raddr,
  output logic [PORTS*DW-1:0]   rdata
);

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk)
    if (we) mem[waddr] <= wdata;

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_rd
      assign rdata[p*DW +: DW] = mem[raddr[p*RW +: RW]];
    end
  endgenerate

endmodule

// File: rtl/opr_read_stage.sv
module opr_read_stage
  import opr_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int DW       = 16,
  parameter int TW       = 4,
  parameter int GROUP    = 3,
  parameter int NSRC     = 2,
  parameter int NDST     = 2,
  parameter int RF_PORTS = 2,
  localparam int RW      = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int NREF    = GROUP * NSRC,
  localparam int NROB    = 1 << TW,
  localparam int IW      = (NREF > 1) ? $clog2(NREF) : 1,
  localparam int CW      = $clog2(NREF + 2) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [GROUP-1:0]         in_uop_valid,
  input  logic [GROUP*TW-1:0]      in_uop_tag,
  input  logic [NREF-1:0]          in_src_valid,
  input  logic [NREF*RW-1:0]       in_src_reg,
  input  logic [GROUP*NDST-1:0]    in_dst_valid,
  input  logic [GROUP*NDST*RW-1:0] in_dst_reg,
  input  logic                     exec_valid,
  input  logic [TW-1:0]            exec_tag,
  input  logic [DW-1:0]            exec_data,
  input  logic                     ret_valid,
  input  logic [RW-1:0]            ret_reg,
  input  logic [TW-1:0]            ret_tag,
  input  logic [DW-1:0]            ret_data,
  output logic                     out_valid,
  output logic [GROUP-1:0]         out_uop_valid,
  output logic [GROUP*TW-1:0]      out_uop_tag,
  output logic [NREF*2-1:0]        out_src_kind,
  output logic [NREF*TW-1:0]       out_src_tag,
  output logic [NREF*DW-1:0]       out_src_data
);

  logic                  accept;
  logic                  busy_q, out_valid_q;
  logic [NREF-1:0]       need_q, cur_need, remain;
  logic [NREG-1:0]       trk_busy, trk_done;
  logic [NREG*TW-1:0]    trk_tag;
  logic [DW-1:0]         rob_mem [NROB];
  logic [NROB*DW-1:0]    rob_flat;
  logic [NREF*2-1:0]     cls_kind;
  logic [NREF*TW-1:0]    cls_tag;
  logic [NREF*DW-1:0]    cls_data;
  logic [NREF-1:0]       cls_need;
  logic [RF_PORTS-1:0]   pick_en;
  logic [RF_PORTS*IW-1:0] pick_idx;
  logic [RF_PORTS*RW-1:0] rf_raddr;
  logic [RF_PORTS*DW-1:0] rf_rdata;
  logic [RW-1:0]         cur_reg [NREF];
  logic [1:0]            h_kind [NREF];
  logic [TW-1:0]         h_tag  [NREF];
  logic [DW-1:0]         h_data [NREF];
  logic [RW-1:0]         h_reg  [NREF];
  logic [GROUP-1:0]      h_uv;
  logic [GROUP*TW-1:0]   h_utag;

  assign in_ready = !busy_q && !flush;
  assign accept   = in_valid && in_ready;

  // Stored results of executed producers, indexed by tag
  always_ff @(posedge clk)
    if (exec_valid) rob_mem[exec_tag] <= exec_data;

  generate
    for (genvar t = 0; t < NROB; t++) begin : g_rob
      assign rob_flat[t*DW +: DW] = rob_mem[t];
    end
  endgenerate

  opr_tracker #(.NREG(NREG), .TW(TW), .GROUP(GROUP), .NDST(NDST)) u_trk (
    .clk(clk), .rst(rst), .flush(flush), .alloc_en(accept),
    .uop_valid(in_uop_valid), .uop_tag(in_uop_tag),
    .dst_valid(in_dst_valid), .dst_reg(in_dst_reg),
    .exec_valid(exec_valid), .exec_tag(exec_tag),
    .ret_valid(ret_valid), .ret_reg(ret_reg), .ret_tag(ret_tag),
    .trk_busy(trk_busy), .trk_tag(trk_tag), .trk_done(trk_done)
  );

  opr_classify #(.NREG(NREG), .DW(DW), .TW(TW), .GROUP(GROUP), .NSRC(NSRC), .NDST(NDST)) u_cls (
    .uop_valid(in_uop_valid), .uop_tag(in_uop_tag),
    .src_valid(in_src_valid), .src_reg(in_src_reg),
    .dst_valid(in_dst_valid), .dst_reg(in_dst_reg),
    .trk_busy(trk_busy), .trk_tag(trk_tag), .trk_done(trk_done),
    .rob_vals(rob_flat), .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_data(exec_data),
    .kind(cls_kind), .tag(cls_tag), .data(cls_data), .need_file(cls_need)
  );

  // First read slots go to the new group, later ones to the held remainder
  assign cur_need = accept ? cls_need : need_q;

  opr_port_pick #(.NREF(NREF), .PORTS(RF_PORTS)) u_pick (
    .need(cur_need), .pick_en(pick_en), .pick_idx(pick_idx), .remain(remain)
  );

  generate
    for (genvar k = 0; k < NREF; k++) begin : g_cur
      assign cur_reg[k] = accept ? in_src_reg[k*RW +: RW] : h_reg[k];
    end
  endgenerate

  always_comb
    for (int p = 0; p < RF_PORTS; p++)
      rf_raddr[p*RW +: RW] = cur_reg[pick_idx[p*IW +: IW]];

  opr_commit_rf #(.NREG(NREG), .DW(DW), .PORTS(RF_PORTS)) u_rf (
    .clk(clk), .we(ret_valid), .waddr(ret_reg), .wdata(ret_data),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy_q      <= 1'b0;
      need_q      <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= 1'b0;
      if (accept) begin
        h_uv   <= in_uop_valid;
        h_utag <= in_uop_tag;
        for (int k = 0; k < NREF; k++) begin
          h_kind[k] <= cls_kind[k*2 +: 2];
          h_tag[k]  <= cls_tag[k*TW +: TW];
          h_data[k] <= cls_data[k*DW +: DW];
          h_reg[k]  <= in_src_reg[k*RW +: RW];
        end
      end
      if (accept || busy_q) begin
        for (int p = 0; p < RF_PORTS; p++)
          if (pick_en[p]) h_data[pick_idx[p*IW +: IW]] <= rf_rdata[p*DW +: DW];
        need_q      <= remain;
        busy_q      <= |remain;
        out_valid_q <= ~|remain;
      end
    end
  end

  assign out_valid     = out_valid_q;
  assign out_uop_valid = h_uv;
  assign out_uop_tag   = h_utag;

  generate
    for (genvar k = 0; k < NREF; k++) begin : g_out
      assign out_src_kind[k*2 +: 2]   = h_kind[k];
      assign out_src_tag[k*TW +: TW]  = h_tag[k];
      assign out_src_data[k*DW +: DW] = h_data[k];

      // R2: file origin only for registers with no tracked writer
      a_r2_file_only_idle: assert property (@(posedge clk) disable iff (rst)
        (accept && cls_kind[k*2 +: 2] == SRC_FILE) |-> !trk_busy[in_src_reg[k*RW +: RW]]);
    end
    for (genvar i = 0; i < GROUP; i++) begin : g_idle
      // R9: invalid micro-op reports no origins
      a_r9_idle_uop_none: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_uop_valid[i]) |-> (out_src_kind[i*NSRC*2 +: NSRC*2] == '0));
    end
  endgenerate

  // Occupancy checker: cycles from acceptance to record
  logic [CW-1:0] cyc_q, exp_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
      exp_q <= '0;
    end else if (accept) begin
      cyc_q <= CW'(1);
      exp_q <= ($countones(cls_need) == 0) ? CW'(1)
             : CW'(($countones(cls_need) + RF_PORTS - 1) / RF_PORTS);
    end else if (busy_q) begin
      cyc_q <= cyc_q + CW'(1);
    end
  end

  // R6: record timing follows the port budget
  a_r6_group_cost: assert property (@(posedge clk) disable iff (rst || flush)
    out_valid |-> (cyc_q == exp_q));

  // R6: upstream held while more file reads remain
  a_r6_ready_held: assert property (@(posedge clk) disable iff (rst || flush)
    (accept && ($countones(cls_need) > RF_PORTS)) |=> !in_ready);

  // R8: flushed group never emits
  a_r8_flush_drops: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  // R6: no more than the port count read per cycle
  a_r6_port_limit: assert property (@(posedge clk) disable iff (rst)
    $countones(cur_need & ~remain) <= RF_PORTS);

endmodule

// File: tb/opr_read_stage_tb.sv
`timescale 1ns/1ps
module opr_read_stage_tb;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0, in_valid = 1'b0;
  logic in_ready;
  logic [2:0]  in_uop_valid = '0;
  logic [11:0] in_uop_tag = '0;
  logic [5:0]  in_src_valid = '0;
  logic [17:0] in_src_reg = '0;
  logic [5:0]  in_dst_valid = '0;
  logic [17:0] in_dst_reg = '0;
  logic        exec_valid = 1'b0;
  logic [3:0]  exec_tag = '0;
  logic [15:0] exec_data = '0;
  logic        ret_valid = 1'b0;
  logic [2:0]  ret_reg = '0;
  logic [3:0]  ret_tag = '0;
  logic [15:0] ret_data = '0;
  logic        out_valid;
  logic [2:0]  out_uop_valid;
  logic [11:0] out_uop_tag;
  logic [11:0] out_src_kind;
  logic [23:0] out_src_tag;
  logic [95:0] out_src_data;

  always #2.5 clk = ~clk;

  opr_read_stage u_dut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_uop_valid(in_uop_valid), .in_uop_tag(in_uop_tag),
    .in_src_valid(in_src_valid), .in_src_reg(in_src_reg),
    .in_dst_valid(in_dst_valid), .in_dst_reg(in_dst_reg),
    .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_data(exec_data),
    .ret_valid(ret_valid), .ret_reg(ret_reg), .ret_tag(ret_tag), .ret_data(ret_data),
    .out_valid(out_valid), .out_uop_valid(out_uop_valid), .out_uop_tag(out_uop_tag),
    .out_src_kind(out_src_kind), .out_src_tag(out_src_tag), .out_src_data(out_src_data)
  );

  int n_chk = 0, n_fail = 0;

  // Reference model of tracking, stored results and committed file
  bit        m_busy [8];
  bit        m_done [8];
  bit [3:0]  m_tag  [8];
  bit [15:0] m_rob  [16];
  bit [15:0] m_file [8];

  // Group under construction
  bit       g_uv [3];
  bit [3:0] g_tag [3];
  bit       g_sv [6];
  bit [2:0] g_sr [6];
  bit       g_dv [6];
  bit [2:0] g_dr [6];

  bit [1:0]  e_kind [6];
  bit [3:0]  e_tag  [6];
  bit [15:0] e_data [6];
  string     e_req  [6];
  int        e_n;

  // Outstanding producers in tag order
  bit       q_v0 [16], q_v1 [16], q_ex [16];
  bit [2:0] q_r0 [16], q_r1 [16];
  bit [15:0] q_val [16];
  int hd = 0, cnt = 0;
  bit [3:0] next_tag = 0;

  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_group();
    for (int i = 0; i < 3; i++) begin g_uv[i] = 0; g_tag[i] = 0; end
    for (int k = 0; k < 6; k++) begin g_sv[k] = 0; g_sr[k] = 0; g_dv[k] = 0; g_dr[k] = 0; end
  endtask

  task automatic set_uop(input int i, input bit [3:0] t);
    g_uv[i] = 1; g_tag[i] = t;
  endtask
  task automatic set_src(input int k, input bit [2:0] r);
    g_sv[k] = 1; g_sr[k] = r;
  endtask
  task automatic set_dst(input int k, input bit [2:0] r);
    g_dv[k] = 1; g_dr[k] = r;
  endtask

  task automatic model_exec(input bit [3:0] t, input bit [15:0] v);
    m_rob[t] = v;
    for (int r = 0; r < 8; r++) if (m_busy[r] && m_tag[r] == t) m_done[r] = 1;
  endtask

  task automatic model_clear();
    for (int r = 0; r < 8; r++) begin m_busy[r] = 0; m_done[r] = 0; end
  endtask

  task automatic compute_expected(input bit xv, input bit [3:0] xt, input bit [15:0] xd);
    e_n = 0;
    for (int k = 0; k < 6; k++) begin
      int i; bit hit; bit [3:0] ht; bit [2:0] r;
      i = k / 2; hit = 0; ht = 0; r = g_sr[k];
      e_kind[k] = 2'b00; e_tag[k] = 0; e_data[k] = 0; e_req[k] = "R9";
      if (g_uv[i] && g_sv[k]) begin
        for (int j = 0; j < i; j++)
          for (int d = 0; d < 2; d++)
            if (g_uv[j] && g_dv[j*2+d] && g_dr[j*2+d] == r) begin hit = 1; ht = g_tag[j]; end
        if (hit) begin
          e_kind[k] = 2'b11; e_tag[k] = ht; e_req[k] = "R5";
        end else if (m_busy[r]) begin
          e_tag[k] = m_tag[r];
          if (m_done[r]) begin
            e_kind[k] = 2'b10; e_data[k] = m_rob[m_tag[r]]; e_req[k] = "R3";
          end else if (xv && xt == m_tag[r]) begin
            e_kind[k] = 2'b10; e_data[k] = xd; e_req[k] = "R10";
          end else begin
            e_kind[k] = 2'b11; e_req[k] = "R4";
          end
        end else begin
          e_kind[k] = 2'b01; e_data[k] = m_file[r]; e_req[k] = "R2"; e_n++;
        end
      end
    end
  endtask

  task automatic load_inputs();
    for (int i = 0; i < 3; i++) begin
      in_uop_valid[i] = g_uv[i];
      in_uop_tag[i*4 +: 4] = g_tag[i];
    end
    for (int k = 0; k < 6; k++) begin
      in_src_valid[k] = g_sv[k];
      in_src_reg[k*3 +: 3] = g_sr[k];
      in_dst_valid[k] = g_dv[k];
      in_dst_reg[k*3 +: 3] = g_dr[k];
    end
  endtask

  task automatic run_group(input bit xv, input bit [3:0] xt, input bit [15:0] xd);
    int k, expc;
    while (!in_ready) @(negedge clk);
    compute_expected(xv, xt, xd);
    expc = (e_n == 0) ? 1 : (e_n + 1) / 2;
    load_inputs();
    in_valid = 1; exec_valid = xv; exec_tag = xt; exec_data = xd;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; exec_valid = 0;
    if (xv) model_exec(xt, xd);
    for (int i = 0; i < 3; i++)
      for (int d = 0; d < 2; d++)
        if (g_uv[i] && g_dv[i*2+d]) begin
          m_busy[g_dr[i*2+d]] = 1; m_done[g_dr[i*2+d]] = 0; m_tag[g_dr[i*2+d]] = g_tag[i];
        end
    k = 1;
    while (!out_valid && k < 12) begin
      check_eq("R6", "in_ready during drain", in_ready, 0);
      @(negedge clk);
      k++;
    end
    check_eq("R6", "cycles to record", k, expc);
    for (int i = 0; i < 3; i++) check_eq("R1", "uop valid", out_uop_valid[i], g_uv[i]);
    for (int j = 0; j < 6; j++) begin
      check_eq(e_req[j], "kind", out_src_kind[j*2 +: 2], e_kind[j]);
      check_eq(e_req[j], "tag", out_src_tag[j*4 +: 4], e_tag[j]);
      check_eq(e_req[j], "data", out_src_data[j*16 +: 16], e_data[j]);
    end
  endtask

  task automatic do_exec(input bit [3:0] t, input bit [15:0] v);
    exec_valid = 1; exec_tag = t; exec_data = v;
    @(posedge clk); @(negedge clk);
    exec_valid = 0;
    model_exec(t, v);
  endtask

  task automatic do_retire(input bit [2:0] r, input bit [3:0] t, input bit [15:0] v);
    ret_valid = 1; ret_reg = r; ret_tag = t; ret_data = v;
    @(posedge clk); @(negedge clk);
    ret_valid = 0;
    m_file[r] = v;
    if (m_busy[r] && m_tag[r] == t) m_busy[r] = 0;
  endtask

  task automatic do_flush();
    flush = 1;
    @(negedge clk);
    check_eq("R8", "in_ready during flush", in_ready, 0);
    @(posedge clk); @(negedge clk);
    flush = 0;
    model_clear();
  endtask

  task automatic retire_head();
    bit [3:0] t;
    t = 4'(hd);
    if (!q_ex[t]) begin q_val[t] = 16'($urandom); do_exec(t, q_val[t]); q_ex[t] = 1; end
    if (q_v0[t]) do_retire(q_r0[t], t, q_val[t]);
    if (q_v1[t]) do_retire(q_r1[t], t, q_val[t]);
    hd = (hd + 1) % 16; cnt--;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check_eq("R1", "in_ready after reset", in_ready, 1);
    check_eq("R1", "out_valid after reset", out_valid, 0);
    model_clear();
    for (int r = 0; r < 8; r++) do_retire(3'(r), 4'd0, 16'h1000 + 16'(r));

    // R6: five file references, register 1 named three times -> 3 cycles
    clear_group();
    set_uop(0, 4'd1); set_uop(1, 4'd2); set_uop(2, 4'd3);
    set_src(0, 3'd1); set_src(1, 3'd2); set_src(2, 3'd1); set_src(3, 3'd3); set_src(4, 3'd1);
    run_group(0, 0, 0);

    // R5: self-move first, later readers pend on it; only one file read
    clear_group();
    set_uop(0, 4'd1); set_uop(1, 4'd2); set_uop(2, 4'd3);
    set_src(0, 3'd1); set_dst(0, 3'd1);
    set_src(2, 3'd1); set_src(3, 3'd1); set_src(4, 3'd1);
    run_group(0, 0, 0);

    // R4: older producer not yet executed
    clear_group(); set_uop(0, 4'd4); set_src(0, 3'd1);
    run_group(0, 0, 0);

    // R3: after execution the stored result is used
    do_exec(4'd1, 16'hA5A5);
    clear_group(); set_uop(0, 4'd4); set_src(0, 3'd1); set_src(1, 3'd1);
    run_group(0, 0, 0);

    // R7: stale retire keeps tracking, matching retire releases it
    do_retire(3'd1, 4'd14, 16'h1111);
    clear_group(); set_uop(0, 4'd4); set_src(0, 3'd1);
    run_group(0, 0, 0);
    do_retire(3'd1, 4'd1, 16'hA5A5);
    clear_group(); set_uop(0, 4'd4); set_src(0, 3'd1);
    run_group(0, 0, 0);

    // R10: write-back in the acceptance cycle is forwarded
    clear_group(); set_uop(0, 4'd9); set_dst(0, 3'd6);
    run_group(0, 0, 0);
    clear_group(); set_uop(0, 4'd10); set_src(0, 3'd6); set_src(1, 3'd2);
    run_group(1, 4'd9, 16'hBEEF);

    // R9: invalid micro-op and unused slots
    clear_group(); set_uop(0, 4'd11); set_src(1, 3'd3);
    g_sv[2] = 1; g_sr[2] = 3'd4; set_uop(2, 4'd12); set_src(5, 3'd5);
    run_group(0, 0, 0);

    // R8: flush during a three-cycle drain
    clear_group();
    for (int i = 0; i < 3; i++) set_uop(i, 4'(i + 1));
    for (int k = 0; k < 6; k++) set_src(k, 3'(k % 3));
    load_inputs();
    while (!in_ready) @(negedge clk);
    in_valid = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    do_flush();
    for (int c = 0; c < 4; c++) begin
      check_eq("R8", "out_valid after flush", out_valid, 0);
      @(negedge clk);
    end
    clear_group(); set_uop(0, 4'd0); set_src(0, 3'd6);
    run_group(0, 0, 0);

    // Random phase
    model_clear(); hd = 0; cnt = 0; next_tag = 0;
    for (int it = 0; it < 150; it++) begin
      if (cnt > 8) while (cnt > 2) retire_head();
      clear_group();
      for (int i = 0; i < 3; i++) begin
        if ($urandom % 8 != 0) begin
          bit [3:0] t;
          t = next_tag;
          set_uop(i, t);
          q_ex[t] = 0; q_v0[t] = 0; q_v1[t] = 0;
          for (int s = 0; s < 2; s++) begin
            if ($urandom % 4 != 0) set_src(i*2+s, 3'($urandom % 8));
            if ($urandom % 3 == 0) set_dst(i*2+s, 3'($urandom % 8));
          end
          q_v0[t] = g_dv[i*2]; q_r0[t] = g_dr[i*2];
          q_v1[t] = g_dv[i*2+1]; q_r1[t] = g_dr[i*2+1];
          next_tag = next_tag + 4'd1; cnt++;
        end
      end
      run_group(0, 0, 0);
      repeat ($urandom % 3) begin
        if (cnt > 0) begin
          bit [3:0] t;
          t = 4'((hd + int'($urandom % cnt)) % 16);
          if (!q_ex[t]) begin q_val[t] = 16'($urandom); do_exec(t, q_val[t]); q_ex[t] = 1; end
        end
      end
      while (cnt > 0 && q_ex[4'(hd)] && ($urandom % 2 == 0)) retire_head();
      if ($urandom % 25 == 0) begin do_flush(); cnt = 0; end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule